// File: doc/BRIEF.md
# Host Bus Wait-State Strobe Generator

This block runs single accesses on an 8-bit parallel host bus. The address and data buses are separate. Each access starts from a request that carries a direction, a chip-select index, an address and write data. The block then drives a one-clock address phase with the chosen chip select and the address valid. After that it drives a read or write strobe for a programmed number of bus clocks. It ends with a one-clock completion cycle. In that cycle the strobe is inactive, read data has been captured, and a done pulse is raised.

Strobe length is coded in steps of two clocks, from 2 to 8 clocks. A separate trim bit takes one clock off, so any length from 1 to 8 clocks can be set. Read and write lengths are programmed independently. Timing can be shared across all chip selects or set per chip select through a selection enable. A burst setting forces a fixed two-clock strobe. The strobe polarity can be chosen.

Top module: `hbws_strobe_gen`

## Requirements
- R1: While reset is asserted and whenever no access is in progress, every chip select is high, both strobes are at their inactive level, the data output enable is low, done is low and busy is low. Reset also clears the captured read data to 0.
- R2: An accepted request produces exactly one address-phase cycle before the strobe. In that cycle, only the selected chip-select line (bit index equal to the request's select number) is low, the address output shows the request address, and neither strobe is active.
- R3: A write strobe stays active for 2, 4, 6 or 8 consecutive clocks for write wait code 0, 1, 2 or 3 respectively.
- R4: A read strobe stays active for 2, 4, 6 or 8 consecutive clocks for read wait code 0, 1, 2 or 3. The write code and write trim have no effect on it, and the read code and read trim have no effect on a write strobe.
- R5: When the trim bit of the access direction is 1, the strobe is one clock shorter than its wait code gives.
- R6: When the per-select enable is 1, the mode, wait codes and trim bits come from the selected chip select's fields. When it is 0, all chip selects use the global fields.
- R7: When burst is 1 at acceptance, the strobe lasts exactly 2 clocks, whatever the wait codes and trim bits are.
- R8: The cycle right after the last active strobe cycle has the strobe inactive and done high for exactly that one cycle. For a read, the read data output then holds the value that was on the data input at the clock edge that ended the strobe.
- R9: With polarity input 0 the strobes are active low. With polarity input 1 they are active high, and the idle level is inverted to match.
- R10: A request whose resolved mode code is not 1 (non-multiplexed) is ignored. Mode code 0 is reserved, and codes 2 and 3 are not supported. Busy stays low, and no chip select or strobe is driven.
- R11: The cycle after done is idle with all chip selects high, so at least one idle cycle always separates two accesses.
- R12: During the address and strobe cycles of a write, the data output enable is high and the data output holds the request write data. The enable is low throughout a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request present; accepted when idle and the mode is valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_cs | input | CS_W | Chip-select index |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | DW | Captured read data |
| glb_mode | input | 2 | Global sub-mode code |
| glb_rd_ws | input | WS_BITS | Global read wait code |
| glb_wr_ws | input | WS_BITS | Global write wait code |
| glb_rd_trim | input | 1 | Global read trim |
| glb_wr_trim | input | 1 | Global write trim |
| burst_en | input | 1 | Fixed two-clock strobe |
| stb_pol_high | input | 1 | Strobe polarity: 1 = active high |
| sel_cfg_en | input | 1 | Use per-select fields |
| sel_mode | input | 2*NUM_CS | Per-select mode codes, select i at bits [2i+1:2i] |
| sel_rd_ws | input | WS_BITS*NUM_CS | Per-select read wait codes |
| sel_wr_ws | input | WS_BITS*NUM_CS | Per-select write wait codes |
| sel_rd_trim | input | NUM_CS | Per-select read trim |
| sel_wr_trim | input | NUM_CS | Per-select write trim |
| hb_cs_n | output | NUM_CS | Active-low chip selects |
| hb_addr | output | AW | Bus address |
| hb_dout | output | DW | Bus write data |
| hb_oe | output | 1 | Write data drive enable |
| hb_din | input | DW | Bus read data |
| hb_rd_stb | output | 1 | Read strobe |
| hb_wr_stb | output | 1 | Write strobe |

## Verification
The strobe length is measured in clocks for every wait code in both directions. When one direction is measured, the other direction's code and trim are set to different values, so a read and write mix-up shows as a wrong length. Each measurement is repeated with trim set, with the global and per-select fields holding different values under each setting of the select enable, and with burst forced over long codes. These runs separate the trim, the source selection and the burst override from one another. Active-high polarity, a reserved mode code, and a reset in the middle of a strobe are run as separate patterns.

// File: rtl/hbws_pkg.sv
package hbws_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_STB  = 2'd2,
    ST_DONE = 2'd3
  } hb_state_e;

  localparam logic [1:0] MODE_NONMUX = 2'd1;
endpackage

// File: rtl/hbws_cfg_sel.sv
module hbws_cfg_sel #(
  parameter int NUM_CS  = 4,
  parameter int WS_BITS = 2,
  localparam int CS_W   = $clog2(NUM_CS)
) (
  input  logic [CS_W-1:0]           req_cs,
  input  logic                      sel_cfg_en,
  input  logic [1:0]                glb_mode,
  input  logic [WS_BITS-1:0]        glb_rd_ws,
  input  logic [WS_BITS-1:0]        glb_wr_ws,
  input  logic                      glb_rd_trim,
  input  logic                      glb_wr_trim,
  input  logic [2*NUM_CS-1:0]       sel_mode,
  input  logic [WS_BITS*NUM_CS-1:0] sel_rd_ws,
  input  logic [WS_BITS*NUM_CS-1:0] sel_wr_ws,
  input  logic [NUM_CS-1:0]         sel_rd_trim,
  input  logic [NUM_CS-1:0]         sel_wr_trim,
  output logic [1:0]                eff_mode,
  output logic [WS_BITS-1:0]        eff_rd_ws,
  output logic [WS_BITS-1:0]        eff_wr_ws,
  output logic                      eff_rd_trim,
  output logic                      eff_wr_trim
);
  logic [1:0]         mode_a [NUM_CS];
  logic [WS_BITS-1:0] rd_ws_a [NUM_CS];
  logic [WS_BITS-1:0] wr_ws_a [NUM_CS];

  for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_slot
    assign mode_a[gi]  = sel_mode[gi*2 +: 2];
    assign rd_ws_a[gi] = sel_rd_ws[gi*WS_BITS +: WS_BITS];
    assign wr_ws_a[gi] = sel_wr_ws[gi*WS_BITS +: WS_BITS];
  end

  always_comb begin
    if (sel_cfg_en) begin
      eff_mode    = mode_a[req_cs];
      eff_rd_ws   = rd_ws_a[req_cs];
      eff_wr_ws   = wr_ws_a[req_cs];
      eff_rd_trim = sel_rd_trim[req_cs];
      eff_wr_trim = sel_wr_trim[req_cs];
    end else begin
      eff_mode    = glb_mode;
      eff_rd_ws   = glb_rd_ws;
      eff_wr_ws   = glb_wr_ws;
      eff_rd_trim = glb_rd_trim;
      eff_wr_trim = glb_wr_trim;
    end
  end
endmodule

// File: rtl/hbws_width.sv
module hbws_width #(
  parameter int WS_BITS = 2,
  localparam int MAX_LEN = 2 << WS_BITS,
  localparam int CNT_W   = $clog2(MAX_LEN + 1)
) (
  input  logic               we,
  input  logic               burst,
  input  logic [WS_BITS-1:0] rd_ws,
  input  logic [WS_BITS-1:0] wr_ws,
  input  logic               rd_trim,
  input  logic               wr_trim,
  output logic [CNT_W-1:0]   len
);
  logic [WS_BITS-1:0] ws;
  logic               trim;
  logic [CNT_W-1:0]   steps;

  always_comb begin
    ws    = we ? wr_ws : rd_ws;
    trim  = we ? wr_trim : rd_trim;
    steps = {{(CNT_W-WS_BITS){1'b0}}, ws} + CNT_W'(1);
    if (burst) len = CNT_W'(2);
    else       len = (steps << 1) - {{(CNT_W-1){1'b0}}, trim};
  end
endmodule

// File: rtl/hbws_seq.sv
module hbws_seq
  import hbws_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  output hb_state_e        state,
  output logic             cap_en
);
  hb_state_e        state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cap_en = (state == ST_STB) && (cnt_q == '0);

  always_comb begin
    state_d = state;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    case (state)
      ST_IDLE: if (start) begin
        state_d = ST_ADDR;
        cnt_d   = len - CNT_W'(1);
        cnt_en  = 1'b1;
      end
      ST_ADDR: state_d = ST_STB;
      ST_STB: begin
        if (cnt_q == '0) state_d = ST_DONE;
        else begin
          cnt_d  = cnt_q - CNT_W'(1);
          cnt_en = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      state <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/hbws_strobe_gen.sv
module hbws_strobe_gen
  import hbws_pkg::*;
#(
  parameter int NUM_CS  = 4,
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int WS_BITS = 2,
  localparam int CS_W    = $clog2(NUM_CS),
  localparam int MAX_LEN = 2 << WS_BITS,
  localparam int CNT_W   = $clog2(MAX_LEN + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic                      req_we,
  input  logic [CS_W-1:0]           req_cs,
  input  logic [AW-1:0]             req_addr,
  input  logic [DW-1:0]             req_wdata,
  output logic                      busy,
  output logic                      done,
  output logic [DW-1:0]             rdata,
  input  logic [1:0]                glb_mode,
  input  logic [WS_BITS-1:0]        glb_rd_ws,
  input  logic [WS_BITS-1:0]        glb_wr_ws,
  input  logic                      glb_rd_trim,
  input  logic                      glb_wr_trim,
  input  logic                      burst_en,
  input  logic                      stb_pol_high,
  input  logic                      sel_cfg_en,
  input  logic [2*NUM_CS-1:0]       sel_mode,
  input  logic [WS_BITS*NUM_CS-1:0] sel_rd_ws,
  input  logic [WS_BITS*NUM_CS-1:0] sel_wr_ws,
  input  logic [NUM_CS-1:0]         sel_rd_trim,
  input  logic [NUM_CS-1:0]         sel_wr_trim,
  output logic [NUM_CS-1:0]         hb_cs_n,
  output logic [AW-1:0]             hb_addr,
  output logic [DW-1:0]             hb_dout,
  output logic                      hb_oe,
  input  logic [DW-1:0]             hb_din,
  output logic                      hb_rd_stb,
  output logic                      hb_wr_stb
);
  logic [1:0]         eff_mode;
  logic [WS_BITS-1:0] eff_rd_ws, eff_wr_ws;
  logic               eff_rd_trim, eff_wr_trim;
  logic [CNT_W-1:0]   len;
  hb_state_e          state;
  logic               cap_en, start, cs_active, stb_on;
  logic               we_q;
  logic [CS_W-1:0]    cs_q;
  logic [AW-1:0]      addr_q;
  logic [DW-1:0]      wdata_q, rdata_q;

  hbws_cfg_sel #(.NUM_CS(NUM_CS), .WS_BITS(WS_BITS)) u_cfg (
    .req_cs(req_cs), .sel_cfg_en(sel_cfg_en),
    .glb_mode(glb_mode), .glb_rd_ws(glb_rd_ws), .glb_wr_ws(glb_wr_ws),
    .glb_rd_trim(glb_rd_trim), .glb_wr_trim(glb_wr_trim),
    .sel_mode(sel_mode), .sel_rd_ws(sel_rd_ws), .sel_wr_ws(sel_wr_ws),
    .sel_rd_trim(sel_rd_trim), .sel_wr_trim(sel_wr_trim),
    .eff_mode(eff_mode), .eff_rd_ws(eff_rd_ws), .eff_wr_ws(eff_wr_ws),
    .eff_rd_trim(eff_rd_trim), .eff_wr_trim(eff_wr_trim)
  );

  hbws_width #(.WS_BITS(WS_BITS)) u_width (
    .we(req_we), .burst(burst_en),
    .rd_ws(eff_rd_ws), .wr_ws(eff_wr_ws),
    .rd_trim(eff_rd_trim), .wr_trim(eff_wr_trim),
    .len(len)
  );

  assign start = req_valid && (state == ST_IDLE) && (eff_mode == MODE_NONMUX);

  hbws_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .len(len),
    .state(state), .cap_en(cap_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      cs_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start) begin
      we_q    <= req_we;
      cs_q    <= req_cs;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rdata_q <= '0;
    else if (cap_en && !we_q)  rdata_q <= hb_din;
  end

  assign cs_active = (state == ST_ADDR) || (state == ST_STB);
  assign stb_on    = (state == ST_STB);

  for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_cs
    assign hb_cs_n[gi] = !(cs_active && (cs_q == CS_W'(gi)));
  end

  assign hb_addr   = addr_q;
  assign hb_dout   = wdata_q;
  assign hb_oe     = cs_active && we_q;
  assign hb_rd_stb = (stb_on && !we_q) ~^ stb_pol_high;
  assign hb_wr_stb = (stb_on && we_q) ~^ stb_pol_high;
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);
  assign rdata     = rdata_q;
endmodule

// File: rtl/hbws_chk.sv
module hbws_chk #(
  parameter int NUM_CS  = 4,
  parameter int WS_BITS = 2,
  localparam int MAX_LEN = 2 << WS_BITS,
  localparam int CW      = $clog2(MAX_LEN + 2) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              hb_oe,
  input logic              stb_pol_high,
  input logic              hb_rd_stb,
  input logic              hb_wr_stb,
  input logic [NUM_CS-1:0] hb_cs_n
);
  logic          rd_act, wr_act;
  logic [CW-1:0] act_cnt;

  assign rd_act = stb_pol_high ? hb_rd_stb : !hb_rd_stb;
  assign wr_act = stb_pol_high ? hb_wr_stb : !hb_wr_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                act_cnt <= '0;
    else if (rd_act || wr_act) act_cnt <= act_cnt + CW'(1);
    else                       act_cnt <= '0;
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ((&hb_cs_n) && !rd_act && !wr_act && !hb_oe));
  // R2
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~hb_cs_n));
  // R2
  addr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!rd_act && !wr_act && !(&hb_cs_n)));
  // R4
  stb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_act && wr_act));
  // R3
  width_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_cnt <= CW'(MAX_LEN));
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ((&hb_cs_n) && !busy));
  // R12
  oe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hb_oe |-> !rd_act);
endmodule

bind hbws_strobe_gen hbws_chk #(.NUM_CS(NUM_CS), .WS_BITS(WS_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .hb_oe(hb_oe),
  .stb_pol_high(stb_pol_high), .hb_rd_stb(hb_rd_stb), .hb_wr_stb(hb_wr_stb),
  .hb_cs_n(hb_cs_n)
);

// File: tb/hbws_strobe_gen_bench.sv
module hbws_strobe_gen_bench;
  localparam int NUM_CS = 4;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int WSB = 2;

  typedef struct packed {
    logic       we;
    logic [1:0] cs;
    logic       en;
    logic [1:0] gws;
    logic [1:0] sws;
    logic       trim;
    logic       burst;
    logic       pol;
    logic [3:0] exp_len;
    logic [3:0] req;
  } vec_t;

  // R3 write codes, R4 read codes, R5 trim, R6 source select, R7 burst, R9 polarity
  localparam vec_t VECS [15] = '{
    '{1'b1, 2'd0, 1'b0, 2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 4'd2, 4'd3},
    '{1'b1, 2'd1, 1'b0, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 4'd4, 4'd3},
    '{1'b1, 2'd2, 1'b0, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 4'd6, 4'd3},
    '{1'b1, 2'd3, 1'b0, 2'd3, 2'd0, 1'b0, 1'b0, 1'b0, 4'd8, 4'd3},
    '{1'b0, 2'd0, 1'b0, 2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 4'd2, 4'd4},
    '{1'b0, 2'd1, 1'b0, 2'd3, 2'd0, 1'b0, 1'b0, 1'b0, 4'd8, 4'd4},
    '{1'b0, 2'd2, 1'b0, 2'd2, 2'd1, 1'b1, 1'b0, 1'b0, 4'd5, 4'd5},
    '{1'b1, 2'd3, 1'b0, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 4'd3, 4'd5},
    '{1'b1, 2'd2, 1'b1, 2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 4'd8, 4'd6},
    '{1'b0, 2'd1, 1'b1, 2'd3, 2'd0, 1'b0, 1'b0, 1'b0, 4'd2, 4'd6},
    '{1'b0, 2'd3, 1'b1, 2'd0, 2'd1, 1'b1, 1'b0, 1'b0, 4'd3, 4'd6},
    '{1'b1, 2'd0, 1'b0, 2'd3, 2'd3, 1'b1, 1'b1, 1'b0, 4'd2, 4'd7},
    '{1'b0, 2'd2, 1'b1, 2'd2, 2'd2, 1'b0, 1'b1, 1'b0, 4'd2, 4'd7},
    '{1'b1, 2'd1, 1'b0, 2'd2, 2'd0, 1'b0, 1'b0, 1'b1, 4'd6, 4'd9},
    '{1'b0, 2'd0, 1'b0, 2'd0, 2'd0, 1'b1, 1'b0, 1'b1, 4'd1, 4'd9}
  };

  logic clk, rst_n;
  logic req_valid, req_we;
  logic [1:0] req_cs;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata, rdata, hb_dout, hb_din;
  logic busy, done, hb_oe, hb_rd_stb, hb_wr_stb;
  logic [1:0] glb_mode;
  logic [WSB-1:0] glb_rd_ws, glb_wr_ws;
  logic glb_rd_trim, glb_wr_trim, burst_en, stb_pol_high, sel_cfg_en;
  logic [2*NUM_CS-1:0] sel_mode;
  logic [WSB*NUM_CS-1:0] sel_rd_ws, sel_wr_ws;
  logic [NUM_CS-1:0] sel_rd_trim, sel_wr_trim, hb_cs_n;
  logic [AW-1:0] hb_addr;

  int checks = 0;
  int errors = 0;

  hbws_strobe_gen #(.NUM_CS(NUM_CS), .AW(AW), .DW(DW), .WS_BITS(WSB)) u_hbws_strobe_gen (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rdata(rdata),
    .glb_mode(glb_mode), .glb_rd_ws(glb_rd_ws), .glb_wr_ws(glb_wr_ws),
    .glb_rd_trim(glb_rd_trim), .glb_wr_trim(glb_wr_trim),
    .burst_en(burst_en), .stb_pol_high(stb_pol_high), .sel_cfg_en(sel_cfg_en),
    .sel_mode(sel_mode), .sel_rd_ws(sel_rd_ws), .sel_wr_ws(sel_wr_ws),
    .sel_rd_trim(sel_rd_trim), .sel_wr_trim(sel_wr_trim),
    .hb_cs_n(hb_cs_n), .hb_addr(hb_addr), .hb_dout(hb_dout), .hb_oe(hb_oe),
    .hb_din(hb_din), .hb_rd_stb(hb_rd_stb), .hb_wr_stb(hb_wr_stb)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input int req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit stb_act(input logic we);
    logic s;
    s = we ? hb_wr_stb : hb_rd_stb;
    return stb_pol_high ? s : !s;
  endfunction

  task automatic run_vec(input vec_t v, input int idx);
    int n;
    logic [AW-1:0] a;
    logic [DW-1:0] d, din;
    a   = AW'(16'h1200 + idx * 3);
    d   = DW'(8'hC3 ^ idx);
    din = DW'(8'h5A ^ (idx << 2));
    @(negedge clk);
    stb_pol_high = v.pol;
    sel_cfg_en   = v.en;
    burst_en     = v.burst;
    sel_rd_ws = '0; sel_wr_ws = '0; sel_rd_trim = '0; sel_wr_trim = '0;
    if (v.we) begin
      glb_wr_ws = v.gws; glb_rd_ws = ~v.gws; glb_wr_trim = v.trim; glb_rd_trim = 1'b1;
      sel_wr_ws[v.cs*2 +: 2] = v.sws; sel_rd_ws[v.cs*2 +: 2] = ~v.sws;
      sel_wr_trim[v.cs] = v.trim; sel_rd_trim[v.cs] = 1'b1;
    end else begin
      glb_rd_ws = v.gws; glb_wr_ws = ~v.gws; glb_rd_trim = v.trim; glb_wr_trim = 1'b1;
      sel_rd_ws[v.cs*2 +: 2] = v.sws; sel_wr_ws[v.cs*2 +: 2] = ~v.sws;
      sel_rd_trim[v.cs] = v.trim; sel_wr_trim[v.cs] = 1'b1;
    end
    hb_din = din;
    req_we = v.we; req_cs = v.cs; req_addr = a; req_wdata = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    // R2 address phase
    check(hb_cs_n == ~(NUM_CS'(1) << v.cs), 2, "addr-phase cs_n", hb_cs_n, ~(NUM_CS'(1) << v.cs));
    check(hb_addr == a, 2, "addr-phase address", hb_addr, a);
    check(!stb_act(1'b0) && !stb_act(1'b1), 2, "strobe idle in addr phase",
          {hb_rd_stb, hb_wr_stb}, 0);
    // R12 write data drive
    check(hb_oe == v.we, 12, "oe in addr phase", hb_oe, v.we);
    if (v.we) check(hb_dout == d, 12, "write data", hb_dout, d);
    n = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (stb_act(v.we)) n++;
      else break;
    end
    check(n == int'(v.exp_len), int'(v.req), "strobe width", n, v.exp_len);
    // R8 done pulse and read capture
    check(done == 1'b1, 8, "done after strobe", done, 1);
    if (!v.we) check(rdata == din, 8, "read capture", rdata, din);
    @(negedge clk);
    // R11 idle gap
    check((&hb_cs_n) && !done && !busy, 11, "idle after done", {hb_cs_n, done, busy}, {NUM_CS'('1), 2'b00});
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_cs = '0; req_addr = '0;
    req_wdata = '0; hb_din = '0; glb_mode = 2'd1; glb_rd_ws = '0; glb_wr_ws = '0;
    glb_rd_trim = 1'b0; glb_wr_trim = 1'b0; burst_en = 1'b0; stb_pol_high = 1'b0;
    sel_cfg_en = 1'b0; sel_mode = {NUM_CS{2'd1}}; sel_rd_ws = '0; sel_wr_ws = '0;
    sel_rd_trim = '0; sel_wr_trim = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check((&hb_cs_n) && hb_rd_stb && hb_wr_stb && !hb_oe && !busy && !done && rdata == '0,
          1, "reset outputs", {hb_cs_n, hb_rd_stb, hb_wr_stb, hb_oe, busy, done}, {NUM_CS'('1), 4'b1100});
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VECS[i]) run_vec(VECS[i], i);

    // R10 reserved global mode ignored
    @(negedge clk);
    stb_pol_high = 1'b0; sel_cfg_en = 1'b0; burst_en = 1'b0; glb_mode = 2'd0;
    req_we = 1'b1; req_cs = 2'd1; req_valid = 1'b1;
    @(negedge clk);
    check(!busy && (&hb_cs_n) && hb_wr_stb && hb_rd_stb, 10, "reserved mode ignored",
          {busy, hb_cs_n}, {1'b0, NUM_CS'('1)});
    @(negedge clk);
    check(!busy && !hb_oe, 10, "reserved mode still idle", busy, 0);
    // R10 unsupported per-select mode 2 ignored, R6 global mode 1 not used
    glb_mode = 2'd1; sel_cfg_en = 1'b1; sel_mode[3:2] = 2'd2;
    @(negedge clk);
    check(!busy && (&hb_cs_n), 10, "per-select mode 2 ignored", busy, 0);
    req_valid = 1'b0; sel_mode = {NUM_CS{2'd1}}; sel_cfg_en = 1'b0;

    // R1 reset in the middle of a strobe
    glb_wr_ws = 2'd3; glb_wr_trim = 1'b0; req_valid = 1'b1; req_cs = 2'd2;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(!hb_wr_stb && busy, 1, "strobe running before reset", {hb_wr_stb, busy}, 2'b01);
    rst_n = 1'b0;
    #1;
    check((&hb_cs_n) && hb_wr_stb && hb_rd_stb && !busy && !hb_oe, 1, "mid-access reset",
          {hb_cs_n, hb_wr_stb, busy}, {NUM_CS'('1), 2'b10});
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done, 1, "idle after reset release", {busy, done}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule